// File: doc/BRIEF.md
# Register-Driven SPI Flash Command Engine

This block is a small SPI master that a host drives through eight byte-wide registers. The host loads an opcode, three address bytes and one trailing data byte, then writes the control register at offset 0. That write picks the SPI clock rate and two counts: how many bytes go out and how many come back. The engine holds chip select low, shifts the outgoing bytes MSB first in SPI mode 0, and captures up to three response bytes that the host can read afterwards.

The outgoing length is a 2-bit code, not a byte count. Only 1, 2, 4 and 5 bytes can be sent. The address registers are placed so that offset 4 goes on the wire first and offset 2 last. Offset 7 has two roles. A write to it sets the trailing data byte, and a read from it returns the third captured byte.

A control write can also set or clear a page-program flag. This flag starts no bus activity. The SPI clock runs at one of two rates, both taken from the system clock through the SLOW_DIV parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: Bit 7 of offset 0 reads 1 from the clock after a start until one clock after chip select rises. When it reads 0 again, the captured bytes are final.
- R2: A control write starts a transfer only when its upper nibble is 0x4 or 0x5. With 0x4 each SCK half-period lasts SLOW_DIV system clocks. With 0x5 it lasts SLOW_DIV/2 system clocks. Any other upper nibble starts no transfer.
- R3: Control bits [1:0] select what is sent, MSB first:
  - 0 sends offset 1.
  - 1 sends offset 1, then offset 7.
  - 2 sends offset 1, then offsets 4, 3 and 2.
  - 3 sends offset 1, then offsets 4, 3, 2 and 7.
- R4: Control bits [3:2] give the number of response bytes, from 0 to 3. These bytes are sampled on rising SCK edges after the last sent bit, while MOSI is held at 0. They are stored at offsets 5, 6 and 7 in arrival order.
- R5: SCK idles low and MOSI changes only on falling SCK edges. Chip select stays low for the whole transfer and rises after the last sampled bit. Exactly 8 × (sent + received) SCK pulses occur.
- R6: A control write while bit 7 of offset 0 is 1 is ignored, including writes that would change the page-program flag.
- R7: Upper nibble 0x2 or 0x3 sets the page-program flag, which reads at bit 4 of offset 0. Writing 0x00 clears it. Neither write produces any SPI activity.
- R8: After reset, chip select is high, SCK is low, and offset 0 reads 0x00. Offset 0 is laid out as {busy, 0, 0, page flag, read count, length code}, and the two counts are latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a control write that arrives in the middle of a transfer. The bench issues such a write between SCK edges and then confirms two things. First, the running transfer keeps its original pulse count and byte order. Second, chip select stays high once busy drops, so no second transfer begins. The window around chip-select release is checked cycle by cycle: busy must still read 1 in the cycle after chip select rises, and 0 in the cycle after that.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int FAST_DIV = SLOW_DIV / 2;
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_M1 = CW'(FAST_DIV - 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;
  st_t st_q;

  logic [7:0]  cmd_q, a2_q, a3_q, a4_q, x7_q;
  logic [23:0] rx_q;
  logic [1:0]  tlen_q, rcnt_q;
  logic        fast_q, pgm_q, sck_q, cs_q;
  logic [39:0] sh_q;
  logic [6:0]  bit_q, last_q, txb_q;
  logic [CW-1:0] div_q;

  wire busy    = (st_q != IDLE);
  wire wr_ctrl = bus_wr && (bus_addr == 3'd0);
  wire start   = wr_ctrl && !busy && (bus_wdata[7:5] == 3'b010);
  wire [CW-1:0] half_m1 = fast_q ? FAST_M1 : SLOW_M1;
  wire [6:0] rel = bit_q - txb_q;

  logic [2:0]  nb_tx;
  logic [39:0] load;
  always_comb begin
    case (bus_wdata[1:0])
      2'd0: begin nb_tx = 3'd1; load = {cmd_q, 32'd0}; end
      2'd1: begin nb_tx = 3'd2; load = {cmd_q, x7_q, 24'd0}; end
      2'd2: begin nb_tx = 3'd4; load = {cmd_q, a4_q, a3_q, a2_q, 8'd0}; end
      default: begin nb_tx = 3'd5; load = {cmd_q, a4_q, a3_q, a2_q, x7_q}; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; a2_q <= '0; a3_q <= '0; a4_q <= '0; x7_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        3'd1: cmd_q <= bus_wdata;
        3'd2: a2_q  <= bus_wdata;
        3'd3: a3_q  <= bus_wdata;
        3'd4: a4_q  <= bus_wdata;
        3'd7: x7_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b0;
    else if (wr_ctrl && !busy) begin
      if (bus_wdata[7:5] == 3'b001) pgm_q <= 1'b1;
      else if (bus_wdata == 8'h00) pgm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IDLE; tlen_q <= '0; rcnt_q <= '0; fast_q <= 1'b0;
      sck_q <= 1'b0; cs_q <= 1'b1; sh_q <= '0; bit_q <= '0;
      last_q <= '0; txb_q <= '0; div_q <= '0; rx_q <= '0;
    end else begin
      case (st_q)
        IDLE: if (start) begin
          st_q   <= RUN;
          tlen_q <= bus_wdata[1:0];
          rcnt_q <= bus_wdata[3:2];
          fast_q <= bus_wdata[4];
          sh_q   <= load;
          txb_q  <= {1'b0, nb_tx, 3'b000};
          last_q <= {1'b0, nb_tx, 3'b000} + {2'b00, bus_wdata[3:2], 3'b000} - 7'd1;
          bit_q  <= '0;
          div_q  <= '0;
          cs_q   <= 1'b0;
        end
        RUN: if (div_q == half_m1) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            if (bit_q >= txb_q) begin
              case (rel[4:3])
                2'd0: rx_q[7:0]   <= {rx_q[6:0],   spi_miso};
                2'd1: rx_q[15:8]  <= {rx_q[14:8],  spi_miso};
                default: rx_q[23:16] <= {rx_q[22:16], spi_miso};
              endcase
            end
          end else begin
            sck_q <= 1'b0;
            if (bit_q == last_q) begin
              cs_q <= 1'b1;
              st_q <= DONE;
            end else begin
              bit_q <= bit_q + 7'd1;
              sh_q  <= {sh_q[38:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + CW'(1);
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = !cs_q && sh_q[39];

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = {busy, 2'b00, pgm_q, rcnt_q, tlen_q};
      3'd1: bus_rdata = cmd_q;
      3'd2: bus_rdata = a2_q;
      3'd3: bus_rdata = a3_q;
      3'd4: bus_rdata = a4_q;
      3'd5: bus_rdata = rx_q[7:0];
      3'd6: bus_rdata = rx_q[15:8];
      default: bus_rdata = rx_q[23:16];
    endcase
  end

  assert_cs_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  assert_idle_sck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_release_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> busy);
  assert_release_then_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> !busy);
  assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> $stable({tlen_q, rcnt_q, fast_q, pgm_q}));
endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, spi_miso = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;

  spi_cmd_engine #(.SLOW_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, sbit = 0, edges = 0, hicnt = 0;
  logic [63:0] rsp = '0, mlog = '0;
  bit done = 1'b0;

  // vector: ctrl, cmd, a2, a3, a4, x7
  localparam logic [47:0] VEC [6] = '{
    48'h40_9F_00_00_00_00, 48'h51_05_00_00_00_C7,
    48'h4E_03_11_22_33_00, 48'h5F_0B_44_55_66_A7,
    48'h47_02_10_20_30_5E, 48'h58_AB_00_00_00_00 };

  always @(negedge spi_cs_n) begin sbit = 0; spi_miso = rsp[63]; end
  always @(posedge spi_sck) if (!spi_cs_n) begin mlog = {mlog[62:0], spi_mosi}; edges++; end
  always @(negedge spi_sck) if (!spi_cs_n) begin sbit++; spi_miso = rsp[63 - sbit]; end
  always @(negedge clk) if (spi_sck) hicnt++;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, s);
      if (!s[7]) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 cs_n", {63'd0, spi_cs_n}, 64'd1);
    check("R8 sck", {63'd0, spi_sck}, 64'd0);
    rd(3'd0, r); check("R8 ctrl", {56'd0, r}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      logic [7:0] c, x;
      int n, rc, h;
      logic [39:0] txw;
      c = VEC[v][47:40];
      n = (c[1:0] == 0) ? 1 : (c[1:0] == 1) ? 2 : (c[1:0] == 2) ? 4 : 5;
      rc = int'(c[3:2]);
      h = c[4] ? DIV/2 : DIV;
      case (c[1:0])
        2'd0: txw = {32'd0, VEC[v][39:32]};
        2'd1: txw = {24'd0, VEC[v][39:32], VEC[v][7:0]};
        2'd2: txw = {8'd0, VEC[v][39:32], VEC[v][15:8], VEC[v][23:16], VEC[v][31:24]};
        default: txw = {VEC[v][39:32], VEC[v][15:8], VEC[v][23:16], VEC[v][31:24], VEC[v][7:0]};
      endcase
      wr(3'd1, VEC[v][39:32]); wr(3'd2, VEC[v][31:24]); wr(3'd3, VEC[v][23:16]);
      wr(3'd4, VEC[v][15:8]); wr(3'd7, VEC[v][7:0]);
      rsp = 64'hA5C3_96E1_5A3C_0FF0 ^ {8{8'(v * 37)}};
      edges = 0; hicnt = 0; mlog = '0;
      wr(3'd0, c);
      rd(3'd0, r); check("R1 busy set", {63'd0, r[7]}, 64'd1);
      wait_idle();
      check("R5 sck pulses", 64'(edges), 64'(8 * (n + rc)));
      check("R2 clock rate", 64'(hicnt), 64'(8 * (n + rc) * h));
      check("R3 wire order", (mlog >> (8 * rc)) & ((64'd1 << (8 * n)) - 1), {24'd0, txw});
      for (int k = 0; k < rc; k++) begin
        rd(3'(5 + k), x);
        check("R4 read byte", {56'd0, x}, (rsp >> (56 - 8 * (n + k))) & 64'hFF);
      end
      if (rc > 0) check("R4 mosi low in read", mlog & ((64'd1 << (8 * rc)) - 1), 64'd0);
      rd(3'd0, r); check("R8 ctrl layout", {56'd0, r}, {56'd0, 4'd0, c[3:0]});
    end

    // R1 busy clears one cycle after cs_n rises
    wr(3'd1, 8'h66); wr(3'd0, 8'h40);
    @(posedge spi_cs_n);
    @(negedge clk); check("R1 busy after release", {63'd0, bus_rdata[7] & (bus_addr == 0)}, 64'd1);
    @(negedge clk); check("R1 busy cleared", {63'd0, bus_rdata[7]}, 64'd0);

    // R6 write while busy ignored
    edges = 0; mlog = '0;
    wr(3'd1, 8'hC3); wr(3'd0, 8'h40);
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h5F);
    wait_idle();
    check("R6 pulses kept", 64'(edges), 64'd8);
    check("R6 byte kept", mlog & 64'hFF, 64'hC3);
    repeat (10) @(negedge clk);
    check("R6 no restart", {63'd0, spi_cs_n}, 64'd1);
    rd(3'd0, r); check("R6 fields kept", {56'd0, r}, 64'h00);

    // R7 page mode flag
    edges = 0;
    wr(3'd0, 8'h20); rd(3'd0, r); check("R7 set 0x2", {63'd0, r[4]}, 64'd1);
    wr(3'd0, 8'h00); rd(3'd0, r); check("R7 clear", {63'd0, r[4]}, 64'd0);
    wr(3'd0, 8'h30); rd(3'd0, r); check("R7 set 0x3", {63'd0, r[4]}, 64'd1);
    repeat (4) @(negedge clk);
    check("R7 no activity", {63'd0, spi_cs_n}, 64'd1);
    wr(3'd0, 8'h00);

    // R2 other nibbles start nothing
    wr(3'd0, 8'h65); wr(3'd0, 8'h1F);
    repeat (4) @(negedge clk);
    rd(3'd0, r); check("R2 no start busy", {63'd0, r[7]}, 64'd0);
    check("R2 no start pulses", 64'(edges), 64'd0);

    done = 1'b1;
    summary();
  end
endmodule